// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address of up to 40 bits by walking a two-level page table held in memory. It fetches one 32-bit entry at a time over a request/response memory port, sets the accessed and dirty flags of the entries it uses by writing them back, and reports the combined user and write attributes of the mapping. Judging whether the access is allowed is left to a separate permission checker. The block has no translation cache.

A walk starts with a one-cycle `reqValid` pulse. It ends with a one-cycle `done` pulse. The result and the fault status stay on the outputs until the next request is accepted. When paging is disabled the block answers at once, without touching memory. A directory entry can either point to a second-level table or, when large pages are enabled, map a 4 MB region whose upper physical bits come from the entry itself. Addresses are formed with word-aligned offsets; the directory base (`cr3`), `pseEn`, `pagingEn` and `a20Mask` must stay stable during a walk.

Top module: `ptw2_walker`

## Requirements
- R1: With `pagingEn` low, an accepted request completes with `physAddr` = {8'h00, reqAddr & a20Mask}, `bigPage`=0, `attrUser`=1, `attrWrite`=1, `fault`=0, and no memory transaction.
- R2: The first transaction of a paged walk reads the directory entry at ({cr3[31:12],12'h000} + {20'h0, addr[31:22], 2'b00}) & a20Mask.
- R3: A fetched entry with bit 0 clear ends the walk with `fault`=1 and `faultCode` = {bit3 reserved=0, bit2 user flag, bit1 write flag, bit0 = 0}, and no further transaction.
- R4: A directory entry with bit 7 set and `pseEn` high maps a 4 MB page: `bigPage`=1 and `physAddr` = {entry[20:13], ({entry[31:22], addr[21:0]} & a20Mask)}. With `pseEn` low the same entry is used as a table pointer.
- R5: A 4 MB directory entry with bit 21 set ends the walk with `fault`=1 and `faultCode` bits 3 and 0 set, bit 2 = user flag, bit 1 = write flag.
- R6: On the table path, a directory entry with accessed bit 5 clear is written back with bit 5 set, to the same address, before the table entry is read; with bit 5 already set no write happens.
- R7: The table entry is read at ({pde[31:12],12'h000} + {20'h0, addr[21:12], 2'b00}) & a20Mask, and a 4 KB mapping gives `physAddr` = {8'h00, ({pte[31:12], addr[11:0]} & a20Mask)}.
- R8: `attrUser` is the AND of bit 2, and the write attribute starts from the AND of bit 1, over the directory and table entries (the directory entry alone for a 4 MB page).
- R9: The final entry is updated with bit 5 set and, for a write, bit 6 set; it is written back to its own address only if that changed its value.
- R10: `attrWrite` is 0 whenever the final entry, after that update, has bit 6 clear.
- R11: At most one memory transaction is outstanding: `memReqValid` is a one-cycle pulse and the next one comes only after `memRespValid` answers the previous one.
- R12: `done` is a one-cycle pulse, and the results hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (accepted when idle) |
| reqAddr | input | 32 | Linear address |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access comes from user level |
| cr3 | input | 32 | Directory base (bits 31:12 used) |
| pseEn | input | 1 | Enable 4 MB pages |
| pagingEn | input | 1 | Enable translation |
| a20Mask | input | 32 | Mask applied to every physical address |
| memReqValid | output | 1 | Memory request strobe |
| memReqWrite | output | 1 | Memory request is a write |
| memReqAddr | output | 32 | Memory word address |
| memWData | output | 32 | Write data |
| memRespValid | input | 1 | Response or write acknowledge |
| memRData | input | 32 | Read data |
| done | output | 1 | Walk finished |
| physAddr | output | 40 | Physical address |
| bigPage | output | 1 | Mapping is a 4 MB page |
| attrUser | output | 1 | Combined user attribute |
| attrWrite | output | 1 | Combined write attribute |
| fault | output | 1 | Walk ended in a fault |
| faultCode | output | 4 | {reserved, user, write, protection} |

## Verification
The case that needs care is a single final-entry fetch that also decides the attributes and the write-back: the dirty update for a write and the removal of the write attribute for a clean entry are judged in the same check cycle. The bench gives reads and writes against entries in every accessed and dirty combination. It compares the write-back log (address, data, order) and `attrWrite` with values computed beforehand from the entry contents. It also loads a large-page directory entry while `pseEn` is low, so that the same memory word is used once as a 4 MB mapping and once as a table pointer.

// File: rtl/ptw2_pkg.sv
package ptw2_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned PA_W   = 40;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CODE_W = 4;

  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_RW      = 1;
  localparam int unsigned BIT_USER    = 2;
  localparam int unsigned BIT_ACC     = 5;
  localparam int unsigned BIT_DIRTY   = 6;
  localparam int unsigned BIT_BIG     = 7;
  localparam int unsigned BIT_BIGRSVD = 21;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_PDE, ST_WB_PDE, ST_READ_PTE, ST_CHECK, ST_WB_PTE, ST_DONE
  } walkStateT;

  typedef struct packed {
    logic capReq;
    logic identity;
    logic capPde;
    logic capBig;
    logic capPte;
    logic setNp;
    logic setRsvd;
    logic useTbl;
    logic wbFinal;
  } strobeT;

  typedef struct packed {
    logic rdPresent;
    logic rdBig;
    logic rdRsvd;
    logic rdAcc;
    logic needWb;
  } statusT;
endpackage

// File: rtl/ptw2_ctrl.sv
module ptw2_ctrl
  import ptw2_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   pagingEn,
  input  logic   memRespValid,
  input  statusT stat,
  output strobeT stb,
  output logic   memReqValid,
  output logic   memReqWrite,
  output logic   done
);
  walkStateT state, stateNext;
  logic pend;
  logic inMem;
  logic respHit;

  assign inMem = (state == ST_READ_PDE) || (state == ST_WB_PDE) ||
                 (state == ST_READ_PTE) || (state == ST_WB_PTE);
  assign memReqValid = inMem && !pend;
  assign memReqWrite = (state == ST_WB_PDE) || (state == ST_WB_PTE);
  assign respHit = pend && memRespValid;
  assign done = (state == ST_DONE);

  always_comb begin
    stateNext = state;
    stb = '0;
    stb.useTbl  = (state == ST_READ_PTE) || (state == ST_WB_PTE);
    stb.wbFinal = (state == ST_WB_PTE);
    case (state)
      ST_IDLE: if (reqValid) begin
        stb.capReq = 1'b1;
        if (!pagingEn) begin
          stb.identity = 1'b1;
          stateNext = ST_DONE;
        end else begin
          stateNext = ST_READ_PDE;
        end
      end
      ST_READ_PDE: if (respHit) begin
        if (!stat.rdPresent) begin
          stb.setNp = 1'b1;
          stateNext = ST_DONE;
        end else if (stat.rdBig) begin
          if (stat.rdRsvd) begin
            stb.setRsvd = 1'b1;
            stateNext = ST_DONE;
          end else begin
            stb.capBig = 1'b1;
            stateNext = ST_CHECK;
          end
        end else begin
          stb.capPde = 1'b1;
          stateNext = stat.rdAcc ? ST_READ_PTE : ST_WB_PDE;
        end
      end
      ST_WB_PDE: if (respHit) stateNext = ST_READ_PTE;
      ST_READ_PTE: if (respHit) begin
        if (!stat.rdPresent) begin
          stb.setNp = 1'b1;
          stateNext = ST_DONE;
        end else begin
          stb.capPte = 1'b1;
          stateNext = ST_CHECK;
        end
      end
      ST_CHECK: stateNext = stat.needWb ? ST_WB_PTE : ST_DONE;
      ST_WB_PTE: if (respHit) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
    end else begin
      state <= stateNext;
      if (memReqValid) pend <= 1'b1;
      else if (respHit) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ptw2_dpath.sv
module ptw2_dpath
  import ptw2_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic [VA_W-1:0]   cr3,
  input  logic              pseEn,
  input  logic [VA_W-1:0]   a20Mask,
  input  logic [DATA_W-1:0] memRData,
  output statusT            stat,
  output logic [VA_W-1:0]   memReqAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [PA_W-1:0]   physAddr,
  output logic              bigPage,
  output logic              attrUser,
  output logic              attrWrite,
  output logic              fault,
  output logic [CODE_W-1:0] faultCode
);
  localparam int unsigned OFS_W  = 12;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned BIG_W  = 22;
  localparam int unsigned HIGH_W = PA_W - VA_W;

  logic [VA_W-1:0]   vaR;
  logic              wrR, usrR, idR, bigR, faultR;
  logic [CODE_W-1:0] codeR;
  logic [DATA_W-1:0] pdeR, entR;
  logic [DATA_W-1:0] newEnt;
  logic [VA_W-1:0]   pdeAddr, pteAddr, lowSmall, lowBig;
  logic              finalDirty;

  assign pdeAddr = ({cr3[VA_W-1:OFS_W], {OFS_W{1'b0}}} +
                    {{(VA_W-IDX_W-2){1'b0}}, vaR[VA_W-1:BIG_W], 2'b00}) & a20Mask;
  assign pteAddr = ({pdeR[DATA_W-1:OFS_W], {OFS_W{1'b0}}} +
                    {{(VA_W-IDX_W-2){1'b0}}, vaR[BIG_W-1:OFS_W], 2'b00}) & a20Mask;

  assign newEnt = entR | (DATA_W'(1) << BIT_ACC) | (DATA_W'(wrR) << BIT_DIRTY);
  assign finalDirty = newEnt[BIT_DIRTY];

  assign stat.rdPresent = memRData[BIT_PRESENT];
  assign stat.rdBig     = memRData[BIT_BIG] && pseEn;
  assign stat.rdRsvd    = memRData[BIT_BIGRSVD];
  assign stat.rdAcc     = memRData[BIT_ACC];
  assign stat.needWb    = (newEnt != entR);

  assign memReqAddr = (stb.useTbl && !bigR) ? pteAddr : pdeAddr;
  assign memWData   = stb.wbFinal ? newEnt : (pdeR | (DATA_W'(1) << BIT_ACC));

  assign lowSmall = {entR[DATA_W-1:OFS_W], vaR[OFS_W-1:0]} & a20Mask;
  assign lowBig   = {entR[DATA_W-1:BIG_W], vaR[BIG_W-1:0]} & a20Mask;

  always_comb begin
    if (idR) begin
      physAddr  = {{HIGH_W{1'b0}}, vaR & a20Mask};
      attrUser  = 1'b1;
      attrWrite = 1'b1;
    end else if (bigR) begin
      physAddr  = {entR[BIT_BIGRSVD-1 -: HIGH_W], lowBig};
      attrUser  = entR[BIT_USER];
      attrWrite = entR[BIT_RW] && finalDirty;
    end else begin
      physAddr  = {{HIGH_W{1'b0}}, lowSmall};
      attrUser  = pdeR[BIT_USER] && entR[BIT_USER];
      attrWrite = pdeR[BIT_RW] && entR[BIT_RW] && finalDirty;
    end
  end

  assign bigPage   = bigR;
  assign fault     = faultR;
  assign faultCode = codeR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaR <= '0; wrR <= 1'b0; usrR <= 1'b0; idR <= 1'b0; bigR <= 1'b0;
      faultR <= 1'b0; codeR <= '0; pdeR <= '0; entR <= '0;
    end else begin
      if (stb.capReq) begin
        vaR <= reqAddr; wrR <= reqWrite; usrR <= reqUser;
        idR <= 1'b0; bigR <= 1'b0; faultR <= 1'b0; codeR <= '0;
      end
      if (stb.identity) idR <= 1'b1;
      if (stb.capPde) pdeR <= memRData;
      if (stb.capPte) entR <= memRData;
      if (stb.capBig) begin
        pdeR <= memRData;
        entR <= memRData;
        bigR <= 1'b1;
      end
      if (stb.setNp) begin
        faultR <= 1'b1;
        codeR  <= {1'b0, usrR, wrR, 1'b0};
      end
      if (stb.setRsvd) begin
        faultR <= 1'b1;
        codeR  <= {1'b1, usrR, wrR, 1'b1};
      end
    end
  end
endmodule

// File: rtl/ptw2_walker.sv
module ptw2_walker
  import ptw2_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic [VA_W-1:0]   cr3,
  input  logic              pseEn,
  input  logic              pagingEn,
  input  logic [VA_W-1:0]   a20Mask,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [VA_W-1:0]   memReqAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRData,
  output logic              done,
  output logic [PA_W-1:0]   physAddr,
  output logic              bigPage,
  output logic              attrUser,
  output logic              attrWrite,
  output logic              fault,
  output logic [CODE_W-1:0] faultCode
);
  strobeT stb;
  statusT stat;

  ptw2_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .pagingEn(pagingEn),
    .memRespValid(memRespValid), .stat(stat), .stb(stb),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .done(done)
  );

  ptw2_dpath dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqUser(reqUser), .cr3(cr3), .pseEn(pseEn), .a20Mask(a20Mask),
    .memRData(memRData), .stat(stat), .memReqAddr(memReqAddr),
    .memWData(memWData), .physAddr(physAddr), .bigPage(bigPage),
    .attrUser(attrUser), .attrWrite(attrWrite), .fault(fault),
    .faultCode(faultCode)
  );
endmodule

// File: rtl/ptw2_sva.sv
module ptw2_sva (
  input logic        clk,
  input logic        rstN,
  input logic        memReqValid,
  input logic        memReqWrite,
  input logic [31:0] memReqAddr,
  input logic [31:0] memWData,
  input logic        memRespValid,
  input logic        done,
  input logic        fault,
  input logic [3:0]  faultCode,
  input logic        pagingEn,
  input logic        reqValid
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rstN) outstanding <= 1'b0;
    else if (memReqValid) outstanding <= 1'b1;
    else if (memRespValid) outstanding <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !outstanding); // R11
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> memWData[5]); // R6
  AST_RSVD_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault && faultCode[3]) |-> faultCode[0]); // R5
  AST_NP_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault && !faultCode[3]) |-> !faultCode[0]); // R3
  AST_NO_MEM_UNPAGED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !pagingEn && !outstanding && !memReqValid) |=> !memReqValid); // R1
  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[1:0] == 2'b00)); // R2
endmodule

bind ptw2_walker ptw2_sva sva_i (
  .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
  .memReqAddr(memReqAddr), .memWData(memWData), .memRespValid(memRespValid),
  .done(done), .fault(fault), .faultCode(faultCode), .pagingEn(pagingEn),
  .reqValid(reqValid)
);

// File: tb/ptw2_walker_tb.sv
module ptw2_walker_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic reqWrite = 1'b0, reqUser = 1'b0;
  logic [31:0] cr3 = 32'h0000_3000;
  logic pseEn = 1'b0, pagingEn = 1'b1;
  logic [31:0] a20Mask = 32'hFFFF_FFFF;
  logic memReqValid, memReqWrite;
  logic [31:0] memReqAddr, memWData;
  logic memRespValid = 1'b0;
  logic [31:0] memRData = '0;
  logic done;
  logic [39:0] physAddr;
  logic bigPage, attrUser, attrWrite, fault;
  logic [3:0] faultCode;

  int checks = 0, fails = 0;
  int txnCount = 0, overlapErr = 0;
  logic [31:0] logAddr [0:15];
  logic [31:0] logData [0:15];
  logic        logWr   [0:15];
  logic [31:0] mem [int unsigned];

  always #4 clk = ~clk;

  ptw2_walker dut_i (.*);

  // memory model: two-cycle latency, one response per request
  logic [1:0] lat = 2'd0;
  logic [31:0] pAddr, pData;
  logic pWr;
  always @(posedge clk) begin
    memRespValid <= 1'b0;
    if (memReqValid) begin
      if (lat != 0) overlapErr <= overlapErr + 1;
      lat <= 2'd2; pAddr <= memReqAddr; pData <= memWData; pWr <= memReqWrite;
      if (txnCount < 16) begin
        logAddr[txnCount] <= memReqAddr;
        logData[txnCount] <= memWData;
        logWr[txnCount]   <= memReqWrite;
      end
      txnCount <= txnCount + 1;
    end else if (lat != 0) begin
      lat <= lat - 2'd1;
      if (lat == 2'd1) begin
        memRespValid <= 1'b1;
        if (pWr) mem[pAddr] = pData;
        else memRData <= mem.exists(pAddr) ? mem[pAddr] : 32'h0;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] a, input logic w, input logic u);
    int n;
    txnCount = 0;
    @(negedge clk);
    reqAddr = a; reqWrite = w; reqUser = u; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk("R12 done seen", 64'(done), 64'd1);
  endtask

  task automatic afterDone(input logic [39:0] pa);
    @(negedge clk);
    chk("R12 done one cycle", 64'(done), 64'd0);
    chk("R12 result held", 64'(physAddr), 64'(pa));
  endtask

  task automatic tReset;
    chk("R12 reset done", 64'(done), 64'd0);
    chk("R11 reset memReqValid", 64'(memReqValid), 64'd0);
  endtask

  task automatic tUnpaged;
    pagingEn = 1'b0;
    walk(32'h1234_5678, 1'b1, 1'b0);
    chk("R1 identity phys", 64'(physAddr), 64'h00_1234_5678);
    chk("R1 attrs", 64'({bigPage, attrUser, attrWrite, fault}), 64'b0110);
    chk("R1 no txn", 64'(txnCount), 64'd0);
    afterDone(40'h00_1234_5678);
    a20Mask = 32'hFFEF_FFFF;
    walk(32'h0010_0ABC, 1'b0, 1'b0);
    chk("R1 a20 identity", 64'(physAddr), 64'h0ABC);
    a20Mask = 32'hFFFF_FFFF;
    pagingEn = 1'b1;
  endtask

  task automatic tSmallRead;
    mem[32'h3004] = 32'h0000_5007;
    mem[32'h5008] = 32'h0009_8003;
    walk(32'h0040_2ABC, 1'b0, 1'b1);
    chk("R7 phys 4K", 64'(physAddr), 64'h00_0009_8ABC);
    chk("R8 attrUser AND", 64'(attrUser), 64'd0);
    chk("R10 clean no write attr", 64'(attrWrite), 64'd0);
    chk("R11 txn count", 64'(txnCount), 64'd4);
    chk("R2 pde read addr", 64'({logWr[0], logAddr[0]}), {31'd0, 1'b0, 32'h3004});
    chk("R6 pde wb", 64'({logWr[1], logAddr[1], logData[1]}), {31'd0, 1'b1, 32'h3004, 32'h5027});
    chk("R7 pte read addr", 64'({logWr[2], logAddr[2]}), {31'd0, 1'b0, 32'h5008});
    chk("R9 pte wb acc", 64'({logWr[3], logAddr[3], logData[3]}), {31'd0, 1'b1, 32'h5008, 32'h0009_8023});
    chk("R3 no fault", 64'(fault), 64'd0);
  endtask

  task automatic tSmallWriteDirty;
    mem[32'h500C] = 32'h000A_1067;
    walk(32'h0040_3010, 1'b1, 1'b0);
    chk("R6 no pde wb", 64'(txnCount), 64'd2);
    chk("R9 no pte wb when unchanged", 64'({logWr[1], logAddr[1]}), {31'd0, 1'b0, 32'h500C});
    chk("R7 phys", 64'(physAddr), 64'h000A_1010);
    chk("R10 dirty keeps write", 64'({attrUser, attrWrite}), 64'b11);
    afterDone(40'h000A_1010);
  endtask

  task automatic tSmallWriteClean;
    mem[32'h5010] = 32'h000B_2025;
    walk(32'h0040_4000, 1'b1, 1'b0);
    chk("R9 dirty wb", 64'({logWr[2], logAddr[2], logData[2]}), {31'd0, 1'b1, 32'h5010, 32'h000B_2065});
    chk("R8 rw AND", 64'({attrUser, attrWrite}), 64'b10);
  endtask

  task automatic tNotPresent;
    walk(32'h0080_0000, 1'b1, 1'b1);
    chk("R3 pde np fault", 64'({fault, faultCode}), 64'b1_0110);
    chk("R3 stop after pde", 64'(txnCount), 64'd1);
    walk(32'h0040_5000, 1'b0, 1'b0);
    chk("R3 pte np fault", 64'({fault, faultCode}), 64'b1_0000);
    chk("R3 pte np txn", 64'(txnCount), 64'd2);
  endtask

  task automatic tBig;
    pseEn = 1'b1;
    mem[32'h300C] = 32'h084B_4083;
    walk(32'h00C1_2345, 1'b0, 1'b0);
    chk("R4 big phys", 64'(physAddr), 64'h5A_0841_2345);
    chk("R4 bigPage", 64'({bigPage, attrUser, attrWrite}), 64'b100);
    chk("R9 big wb", 64'({logWr[1], logAddr[1], logData[1]}), {31'd0, 1'b1, 32'h300C, 32'h084B_40A3});
    mem[32'h3010] = 32'h0820_0083;
    walk(32'h0100_0000, 1'b0, 1'b1);
    chk("R5 rsvd fault", 64'({fault, faultCode}), 64'b1_1101);
    chk("R5 txn", 64'(txnCount), 64'd1);
    pseEn = 1'b0;
    mem[32'h084B_4048] = 32'h0000_7067;
    walk(32'h00C1_2345, 1'b0, 1'b0);
    chk("R4 pse off table path", 64'({bigPage, physAddr}), {23'd0, 1'b0, 40'h0000_7345});
    chk("R4 pse off pte addr", 64'(logAddr[1]), 64'h084B_4048);
    chk("R8 pde user masks", 64'({attrUser, attrWrite}), 64'b01);
  endtask

  task automatic tA20;
    cr3 = 32'h0010_3000;
    a20Mask = 32'hFFEF_FFFF;
    mem[32'h3000] = 32'h0;
    walk(32'h0000_0000, 1'b0, 1'b0);
    chk("R2 a20 on pde addr", 64'(logAddr[0]), 64'h3000);
    chk("R3 fault", 64'(fault), 64'd1);
    cr3 = 32'h0000_3000;
    a20Mask = 32'hFFFF_FFFF;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tUnpaged();
    tSmallRead();
    tSmallWriteDirty();
    tSmallWriteClean();
    tNotPresent();
    tBig();
    tA20();
    chk("R11 no overlapping requests", 64'(overlapErr), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule